// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a parameterised number of level-sensitive interrupt inputs and folds them onto a small set of output lines. The number of inputs is a multiple of 32. Each output line serves one group of 64 inputs. Every input has a software mask bit and a software-force bit. An input counts as pending when its line is high or its force bit is set, and it reaches the output combining only when its mask bit enables it.

Software controls the block through a simple 32-bit word-addressed register port. A channel-select register gates every output: outputs drive only while the bit that belongs to this instance's channel is set. A global disable bit forces all outputs low. A summary register always reports the ungated level of each output group.

Inside each bank, the register words run in reverse group order. Word 0 holds the highest-numbered 32 inputs.

Top module: `irq_steer_agg`

## Requirements
- R1: After reset, the channel, mask, force and disable registers read 0, and every output is low.
- R2: Mask word w is at byte offset 4+4w, for w from 0 to R−1, where R = NUM_IN/32. It is read/write. Input i lives in word R−1−(i/32), at bit i%32. A mask bit of 1 enables its input, and a 0 blocks it.
- R3: Force word w is at byte offset 4R+4+4w and is read/write. A force bit of 1 makes its input pending even when the input line is low.
- R4: Status word w is at byte offset 8R+4+4w and uses the same bit mapping as the mask bank. Each bit reads (input level OR force bit) AND mask bit.
- R5: Output n is the OR of the status bits of inputs 64n to 64n+63. It appears one clock after the state that causes it, while the channel bit is set and the global disable bit is clear.
- R6: The channel register is at offset 0 and is read/write in its low NUM_CHAN bits; higher bits read 0. While bit CHAN_ID is 0, all outputs are low one clock later.
- R7: The disable register is at offset 12R+4, and only bit 0 is stored. While that bit is 1, all outputs are low one clock later.
- R8: The summary register is at offset 12R+8. Bit n reads the ungated OR of group n, whatever the channel and disable bits hold.
- R9: Writes to the status words and to the summary register change no register. Reads of unmapped or misaligned offsets return 0.
- R10: Status follows the input level. When an input line drops and its force bit is clear, its status bit clears and its output falls one clock later.
- R11: Read data is registered. It is valid in the clock after the read strobe, and it is 0 in any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IN | Level-sensitive interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | NUM_OUT | Aggregated output lines, one per 64 inputs |

## Verification
The hardest point to reach is the reversed word order: a mapping fault only shows when a single input is singled out and tracked to both its status word and its output group. The bench therefore sweeps a one-hot pattern across all 128 inputs. For each position it reads the status word and the summary register and samples the outputs, with the expected word, bit and group computed from the input index. Corner mask and force bits at both ends of the bank confirm the mapping from the software side.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_MASK,
        SEL_FORCE,
        SEL_STAT,
        SEL_MDIS,
        SEL_MSUM
    } sel_e;

    typedef struct packed {
        sel_e       sel;
        logic [4:0] idx;
    } dec_t;

    // Byte offset -> register bank and word index, for R words per bank.
    function automatic dec_t decode(input int unsigned a, input int unsigned r);
        dec_t d;
        int unsigned wa;
        d.sel = SEL_NONE;
        d.idx = '0;
        wa    = a >> 2;
        if ((a & 32'd3) != 0) begin
            d.sel = SEL_NONE;
        end else if (wa == 0) begin
            d.sel = SEL_CTRL;
        end else if (wa <= r) begin
            d.sel = SEL_MASK;
            d.idx = 5'(wa - 1);
        end else if (wa <= 2 * r) begin
            d.sel = SEL_FORCE;
            d.idx = 5'(wa - r - 1);
        end else if (wa <= 3 * r) begin
            d.sel = SEL_STAT;
            d.idx = 5'(wa - 2 * r - 1);
        end else if (wa == 3 * r + 1) begin
            d.sel = SEL_MDIS;
        end else if (wa == 3 * r + 2) begin
            d.sel = SEL_MSUM;
        end
        return d;
    endfunction

endpackage

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int NUM_IN   = 128,
    parameter int NUM_CHAN = 8,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [NUM_CHAN-1:0] ctrl_q,
    output logic                mdis_q,
    output logic [NUM_IN-1:0]   mask_q,
    output logic [NUM_IN-1:0]   force_q
);
    localparam int R = NUM_IN / 32;

    typedef struct packed {
        logic [NUM_CHAN-1:0] ctrl;
        logic                mdis;
        logic [NUM_IN-1:0]   mask;
        logic [NUM_IN-1:0]   frc;
    } st_t;

    st_t  st_d, st_q;
    dec_t dec;

    always_comb begin
        dec  = decode(32'(addr), R);
        st_d = st_q;
        if (wr_en) begin
            unique case (dec.sel)
                SEL_CTRL: st_d.ctrl = wdata[NUM_CHAN-1:0];
                SEL_MDIS: st_d.mdis = wdata[0];
                SEL_MASK: begin
                    for (int w = 0; w < R; w++) begin
                        if (dec.idx == 5'(w)) st_d.mask[(R-1-w)*32 +: 32] = wdata;
                    end
                end
                SEL_FORCE: begin
                    for (int w = 0; w < R; w++) begin
                        if (dec.idx == 5'(w)) st_d.frc[(R-1-w)*32 +: 32] = wdata;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q  = st_q.ctrl;
    assign mdis_q  = st_q.mdis;
    assign mask_q  = st_q.mask;
    assign force_q = st_q.frc;

    // R9: a write aimed at a read-only word leaves the stored state untouched
    p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (dec.sel == SEL_STAT || dec.sel == SEL_MSUM))
        |=> ($stable(mask_q) && $stable(force_q) && $stable(ctrl_q) && $stable(mdis_q)));

    // R1: the first cycle after reset release starts from cleared state
    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (ctrl_q == '0 && mask_q == '0 && force_q == '0 && !mdis_q));

endmodule

// File: rtl/irqagg_combine.sv
module irqagg_combine #(
    parameter int NUM_IN  = 128,
    parameter int NUM_OUT = (NUM_IN + 63) / 64
) (
    input  logic [NUM_IN-1:0]  irq_in,
    input  logic [NUM_IN-1:0]  mask_q,
    input  logic [NUM_IN-1:0]  force_q,
    output logic [NUM_IN-1:0]  status,
    output logic [NUM_OUT-1:0] grp
);
    always_comb begin
        status = (irq_in | force_q) & mask_q;
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_grp
        localparam int LO = g * 64;
        localparam int HI = (LO + 63 < NUM_IN) ? LO + 63 : NUM_IN - 1;
        assign grp[g] = |status[HI:LO];
    end

    // R4: no status bit survives a cleared mask bit
    always_comb begin
        a_masked_r4: assert ((status & ~mask_q) == '0);
    end

endmodule

// File: rtl/irqagg_rdmux.sv
module irqagg_rdmux
    import irqagg_pkg::*;
#(
    parameter int NUM_IN   = 128,
    parameter int NUM_OUT  = (NUM_IN + 63) / 64,
    parameter int NUM_CHAN = 8,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_CHAN-1:0] ctrl_q,
    input  logic                mdis_q,
    input  logic [NUM_IN-1:0]   mask_q,
    input  logic [NUM_IN-1:0]   force_q,
    input  logic [NUM_IN-1:0]   status,
    input  logic [NUM_OUT-1:0]  grp,
    output logic [31:0]         rdata
);
    localparam int R = NUM_IN / 32;

    logic [31:0] rdata_d, rdata_q;
    dec_t        dec;

    always_comb begin
        dec     = decode(32'(addr), R);
        rdata_d = '0;
        if (rd_en) begin
            unique case (dec.sel)
                SEL_CTRL: rdata_d = 32'(ctrl_q);
                SEL_MDIS: rdata_d = {31'b0, mdis_q};
                SEL_MSUM: rdata_d = 32'(grp);
                SEL_MASK: begin
                    for (int w = 0; w < R; w++)
                        if (dec.idx == 5'(w)) rdata_d = mask_q[(R-1-w)*32 +: 32];
                end
                SEL_FORCE: begin
                    for (int w = 0; w < R; w++)
                        if (dec.idx == 5'(w)) rdata_d = force_q[(R-1-w)*32 +: 32];
                end
                SEL_STAT: begin
                    for (int w = 0; w < R; w++)
                        if (dec.idx == 5'(w)) rdata_d = status[(R-1-w)*32 +: 32];
                end
                default: rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R9: unmapped or misaligned reads return zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dec.sel == SEL_NONE) |=> (rdata == '0));

    // R11: no strobe, no data
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));

endmodule

// File: rtl/irq_steer_agg.sv
module irq_steer_agg #(
    parameter int NUM_IN   = 128,
    parameter int NUM_CHAN = 8,
    parameter int CHAN_ID  = 0,
    parameter int ADDR_W   = 12,
    localparam int NUM_OUT = (NUM_IN + 63) / 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IN-1:0]  irq_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic [NUM_OUT-1:0] irq_out
);
    logic [NUM_CHAN-1:0] ctrl_q;
    logic                mdis_q;
    logic [NUM_IN-1:0]   mask_q;
    logic [NUM_IN-1:0]   force_q;
    logic [NUM_IN-1:0]   status;
    logic [NUM_OUT-1:0]  grp;
    logic [NUM_OUT-1:0]  irq_d, irq_q;
    logic                gate_open;

    irqagg_regs #(
        .NUM_IN(NUM_IN), .NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ctrl_q(ctrl_q), .mdis_q(mdis_q), .mask_q(mask_q), .force_q(force_q)
    );

    irqagg_combine #(
        .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)
    ) u_comb (
        .irq_in(irq_in), .mask_q(mask_q), .force_q(force_q),
        .status(status), .grp(grp)
    );

    irqagg_rdmux #(
        .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
        .ctrl_q(ctrl_q), .mdis_q(mdis_q), .mask_q(mask_q), .force_q(force_q),
        .status(status), .grp(grp), .rdata(rdata)
    );

    always_comb begin
        gate_open = ctrl_q[CHAN_ID] && !mdis_q;
        irq_d     = gate_open ? grp : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_out = irq_q;

    // R7: global disable silences every output on the next clock
    p_disable_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mdis_q |=> (irq_out == '0));

    // R6: a cleared channel bit silences every output on the next clock
    p_chan_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CHAN_ID] |=> (irq_out == '0));

    // R5: with the gate open the outputs track the group ORs one clock later
    p_follow_grp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CHAN_ID] && !mdis_q) |=> (irq_out == $past(grp)));

    // R8: an output never rises without its group being active
    p_out_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_out & ~$past(grp)) == '0));

endmodule

// File: tb/tb_irq_steer_agg.sv
module tb_irq_steer_agg;
    localparam int NI   = 128;
    localparam int R    = NI / 32;
    localparam int NO   = (NI + 63) / 64;
    localparam int AW   = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NI-1:0]   irq_in = '0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NO-1:0]   irq_out;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_steer_agg #(.NUM_IN(NI), .NUM_CHAN(8), .CHAN_ID(0), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    function automatic logic [AW-1:0] o_mask(input int w);  return AW'(4 + 4*w);       endfunction
    function automatic logic [AW-1:0] o_force(input int w); return AW'(4*R + 4 + 4*w); endfunction
    function automatic logic [AW-1:0] o_stat(input int w);  return AW'(8*R + 4 + 4*w); endfunction
    localparam logic [AW-1:0] O_CTRL = '0;
    localparam logic [AW-1:0] O_MDIS = AW'(12*R + 4);
    localparam logic [AW-1:0] O_MSUM = AW'(12*R + 8);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic mask_all(input logic [31:0] v);
        for (int w = 0; w < R; w++) wr(o_mask(w), v);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq_out", 32'(irq_out), 0);
        rd(O_CTRL, d);     chk("R1 ctrl", d, 0);
        rd(o_mask(0), d);  chk("R1 mask0", d, 0);
        rd(o_force(R-1), d); chk("R1 force", d, 0);
        rd(O_MDIS, d);     chk("R1 mdis", d, 0);
        rd(O_MSUM, d);     chk("R1 msum", d, 0);

        // R6: channel register width
        wr(O_CTRL, 32'hFFFF_FFFF);
        rd(O_CTRL, d); chk("R6 ctrl width", d, 32'h0000_00FF);
        wr(O_CTRL, 32'h1);
        rd(O_CTRL, d); chk("R6 ctrl readback", d, 32'h1);

        // R2: mask readback per word
        for (int w = 0; w < R; w++) wr(o_mask(w), 32'hA500_0000 | 32'(w));
        for (int w = 0; w < R; w++) begin
            rd(o_mask(w), d); chk("R2 mask rw", d, 32'hA500_0000 | 32'(w));
        end

        // R4 R5 R8: one-hot sweep over every input
        mask_all(32'hFFFF_FFFF);
        for (int i = 0; i < NI; i++) begin
            @(negedge clk); irq_in = '0; irq_in[i] = 1'b1;
            settle();
            chk("R5 sweep out", 32'(irq_out), 32'(1) << (i / 64));
            rd(o_stat(R - 1 - i / 32), d);
            chk("R4 sweep status", d, 32'(1) << (i % 32));
            rd(O_MSUM, d);
            chk("R8 sweep msum", d, 32'(1) << (i / 64));
        end

        // R2: word 0 bit 31 is input NI-1; word R-1 bit 0 is input 0
        @(negedge clk); irq_in = '1;
        mask_all(0);
        wr(o_mask(0), 32'h8000_0000);
        settle(); chk("R2 top input group", 32'(irq_out), 32'b10);
        wr(o_mask(0), 0);
        wr(o_mask(R-1), 32'h1);
        settle(); chk("R2 bottom input group", 32'(irq_out), 32'b01);
        // R2: masked input blocked (input 70 -> word 1 bit 6)
        mask_all(32'hFFFF_FFFF);
        wr(o_mask(1), 32'hFFFF_FFBF);
        @(negedge clk); irq_in = '0; irq_in[70] = 1'b1;
        settle(); chk("R2 masked out", 32'(irq_out), 0);
        rd(o_stat(1), d); chk("R2 masked status", d, 0);
        wr(o_mask(1), 32'hFFFF_FFFF);

        // R3: force bits
        @(negedge clk); irq_in = '0;
        wr(o_force(R-1), 32'h8);
        rd(o_force(R-1), d); chk("R3 force rw", d, 32'h8);
        settle(); chk("R3 forced out", 32'(irq_out), 32'b01);
        rd(o_stat(R-1), d); chk("R3 forced status", d, 32'h8);
        wr(o_mask(R-1), 0);
        settle(); chk("R3 forced but masked", 32'(irq_out), 0);
        wr(o_mask(R-1), 32'hFFFF_FFFF);
        wr(o_force(R-1), 0);

        // R10: level following
        @(negedge clk); irq_in = '0; irq_in[100] = 1'b1;
        settle(); chk("R10 high", 32'(irq_out), 32'b10);
        @(negedge clk); irq_in[100] = 1'b0;
        rd(o_stat(0), d); chk("R10 status drop", d, 0);
        settle(); chk("R10 out drop", 32'(irq_out), 0);

        // R6 R8: other channel selected
        @(negedge clk); irq_in = '0; irq_in[5] = 1'b1; irq_in[64] = 1'b1;
        wr(O_CTRL, 32'h2);
        settle(); chk("R6 gated", 32'(irq_out), 0);
        rd(O_MSUM, d); chk("R8 msum gated", d, 32'b11);
        wr(O_CTRL, 32'h1);
        settle(); chk("R6 open", 32'(irq_out), 32'b11);

        // R7: global disable
        wr(O_MDIS, 32'hFFFF_FFFF);
        rd(O_MDIS, d); chk("R7 mdis width", d, 32'h1);
        settle(); chk("R7 disabled", 32'(irq_out), 0);
        rd(O_MSUM, d); chk("R8 msum disabled", d, 32'b11);
        wr(O_MDIS, 0);
        settle(); chk("R7 reenabled", 32'(irq_out), 32'b11);

        // R9: read-only and unmapped
        wr(o_stat(R-1), 0);
        rd(o_stat(R-1), d); chk("R9 status ro", d, 32'h20);
        wr(O_MSUM, 0);
        rd(O_MSUM, d); chk("R9 msum ro", d, 32'b11);
        rd(o_mask(R-1), d); chk("R9 mask intact", d, 32'hFFFF_FFFF);
        rd(AW'(12*R + 12), d); chk("R9 unmapped", d, 0);
        rd(AW'(12'h200), d); chk("R9 far unmapped", d, 0);
        rd(AW'(6), d); chk("R9 misaligned", d, 0);

        // R11: data is cleared when no strobe
        @(negedge clk); chk("R11 idle rdata", rdata, 0);

        summary();
        $finish;
    end
endmodule